// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves one programmed burst of 128-bit quadwords from a small on-block payload buffer to a downstream packet consumer. Software, or a test harness, fills the buffer through a narrow load port. It then programs an address word, a quadword count and a control word. Setting the start bit in the control word launches one direct-mode transfer.

Each transfer walks a four-state lifecycle: idle, armed, active, done. While active, the block offers beats on a valid/ready port. After the last beat it keeps waiting until the consumer raises a completion strobe. The address word is never used to fetch data. It is kept so that it can be reported.

Every stage of the lifecycle leaves a record on a registered trace port. The stages are configuration capture, transfer start, each accepted beat and completion. A bring-up environment can use these records to prove that the controller, not a shortcut, owned the transfer.

Top module: `dma1_xfer_ctrl`

## Requirements
- R1: After reset the block is idle. A read of the control word returns 0, `pl_valid` is 0 and `tr_valid` is 0.
- R2: Register map (`reg_addr`):
  - 0 is control. On write, bit 0 is start, bits 2:1 are mode and bit 3 is direction. On read, bit 0 is busy, bits 2:1 are mode, bit 3 is direction and bits 5:4 are the state (0 idle, 1 armed, 2 active, 3 done).
  - 1 is the 32-bit address.
  - 2 is the quadword count, in its low 16 bits.
  - `reg_rdata` shows the word selected by `reg_addr` one clock later.
- R3: A start write while idle enters the armed state for one cycle. That cycle produces a configuration trace (kind 1) with arg0 = channel id, arg1 = {direction, mode}, arg2 = address and arg3 = count.
- R4: With mode 0 and a nonzero count, the block then enters the active state. A start trace (kind 2) follows with arg0 = channel id, arg1 = count, arg2 = planned beats (equal to the count) and arg3 = path id.
- R5: The block issues exactly `count` beats. Beat i carries buffer entry i modulo the buffer depth. A beat moves only when `pl_valid` and `pl_ready` are both high. While it waits, `pl_valid` and `pl_data` hold steady.
- R6: Each accepted beat yields a beat trace (kind 3) with arg0 = channel id, arg1 = beat index, arg2 = low 32 bits of the beat and arg3 = beats still to go after it.
- R7: After the last beat the block stays active until `cons_done` is high. A `cons_done` raised while beats remain does not end the transfer early.
- R8: Completion enters the done state for one cycle and yields a done trace (kind 4). Its arg0 is the channel id, arg1 the beats transferred, arg2 the completion code (1 on success) and arg3 the path id. The block then returns to idle and busy reads 0.
- R9: A count of 0 with mode 0 goes from armed straight to done with completion code 2. It emits no start trace and no beats.
- R10: A nonzero mode is unsupported. It goes from armed straight to done with completion code 3 and no beats.
- R11: Register writes, including a second start, are ignored while the block is not idle.
- R12: Buffer loads are ignored while the block is not idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected word |
| ld_we | input | 1 | Payload buffer load strobe |
| ld_addr | input | 3 | Payload buffer entry |
| ld_data | input | 128 | Quadword to load |
| pl_valid | output | 1 | Beat offered to the consumer |
| pl_data | output | 128 | Beat contents |
| pl_ready | input | 1 | Consumer takes the beat |
| cons_done | input | 1 | Consumer completion strobe |
| tr_valid | output | 1 | Trace record present |
| tr_kind | output | 3 | Trace kind (1 cfg, 2 start, 3 beat, 4 done) |
| tr_arg0 | output | 32 | Trace argument 0 |
| tr_arg1 | output | 32 | Trace argument 1 |
| tr_arg2 | output | 32 | Trace argument 2 |
| tr_arg3 | output | 32 | Trace argument 3 |

## Verification
The bench targets several corner cases:
- A count of 0. A design that mishandles it would emit a phantom beat or hang waiting for the consumer.
- An unsupported mode. A design that mishandles it would run it as a normal transfer.
- A completion strobe held high from the start. A design that sampled it too eagerly would finish before its beats.
- Counts larger than the buffer depth. A wrong index would repeat or skip entries.
- Register writes and buffer loads landing mid-transfer. A design that let them through would retarget the address or swap the data of a late beat.

Random ready throttling exposes any beat that is dropped or duplicated while the consumer stalls.

// File: rtl/dma1_pkg.sv
package dma1_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_DONE   = 2'd3
  } xfer_state_e;

  // trace record kinds
  localparam logic [2:0] TK_CFG   = 3'd1;
  localparam logic [2:0] TK_START = 3'd2;
  localparam logic [2:0] TK_BEAT  = 3'd3;
  localparam logic [2:0] TK_DONE  = 3'd4;

  // completion codes
  localparam logic [1:0] CC_OK      = 2'd1;
  localparam logic [1:0] CC_EMPTY   = 2'd2;
  localparam logic [1:0] CC_BADMODE = 2'd3;

  // register offsets
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_ADDR = 2'd1;
  localparam logic [1:0] RA_CNT  = 2'd2;

endpackage

// File: rtl/dma1_regs.sv
module dma1_regs
  import dma1_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             busy,
  input  xfer_state_e      state,
  output logic [31:0]      reg_rdata,
  output logic             start_req,
  output logic [1:0]       mode,
  output logic             dir,
  output logic [31:0]      madr,
  output logic [CNT_W-1:0] qwc
);

  logic wr_ok;
  assign wr_ok     = reg_we && !busy;
  assign start_req = wr_ok && (reg_addr == RA_CTRL) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      dir  <= 1'b0;
      madr <= '0;
      qwc  <= '0;
    end else if (wr_ok) begin
      case (reg_addr)
        RA_CTRL: begin
          mode <= reg_wdata[2:1];
          dir  <= reg_wdata[3];
        end
        RA_ADDR: madr <= reg_wdata;
        RA_CNT:  qwc  <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= {26'd0, state, dir, mode, busy};
        RA_ADDR: reg_rdata <= madr;
        RA_CNT:  reg_rdata <= 32'(qwc);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R11: configuration is frozen for the whole transfer
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(madr) && $stable(qwc) && $stable(mode) && $stable(dir)));

endmodule

// File: rtl/dma1_buf.sv
module dma1_buf #(
  parameter int AW = 3,
  parameter int W  = 128
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/dma1_fsm.sv
module dma1_fsm
  import dma1_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] qwc,
  input  logic             pl_ready,
  input  logic             cons_done,
  output xfer_state_e      state,
  output logic             busy,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             pl_valid,
  output logic             ev_cfg,
  output logic             ev_start,
  output logic             ev_beat,
  output logic             ev_done,
  output logic [CNT_W-1:0] accepted,
  output logic [1:0]       done_code
);

  logic [CNT_W-1:0] issued;
  logic             rd_pend;
  logic             first;
  logic             beat_fire;

  assign busy      = (state != ST_IDLE);
  assign beat_fire = pl_valid && pl_ready;
  assign rd_en     = (state == ST_ACTIVE) && !pl_valid && !rd_pend && (issued < qwc);
  assign rd_addr   = issued[AW-1:0];

  assign ev_cfg   = (state == ST_ARMED);
  assign ev_start = (state == ST_ACTIVE) && first;
  assign ev_beat  = beat_fire;
  assign ev_done  = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      issued    <= '0;
      accepted  <= '0;
      rd_pend   <= 1'b0;
      pl_valid  <= 1'b0;
      first     <= 1'b0;
      done_code <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            state    <= ST_ARMED;
            issued   <= '0;
            accepted <= '0;
          end
        end
        ST_ARMED: begin
          if (mode != 2'd0) begin
            state     <= ST_DONE;
            done_code <= CC_BADMODE;
          end else if (qwc == '0) begin
            state     <= ST_DONE;
            done_code <= CC_EMPTY;
          end else begin
            state <= ST_ACTIVE;
            first <= 1'b1;
          end
        end
        ST_ACTIVE: begin
          first <= 1'b0;
          if (rd_en) begin
            issued  <= issued + CNT_W'(1);
            rd_pend <= 1'b1;
          end
          if (rd_pend) begin
            rd_pend  <= 1'b0;
            pl_valid <= 1'b1;
          end
          if (beat_fire) begin
            pl_valid <= 1'b0;
            accepted <= accepted + CNT_W'(1);
          end
          if ((accepted == qwc) && cons_done) begin
            state     <= ST_DONE;
            done_code <= CC_OK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: armed is entered only from idle
  a_r3_armed_from_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED) |-> ($past(state) == ST_IDLE));

  // R7: without the consumer strobe the transfer stays active
  a_r7_wait_done: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_ACTIVE) && !cons_done) |=> (state == ST_ACTIVE));

  // R8: done lasts one cycle and returns to idle
  a_r8_done_to_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE));

  // R9/R10: empty or unsupported transfers never become active
  a_r9_no_empty_active: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACTIVE) |-> ((qwc != '0) && (mode == 2'd0)));

  // R5: never more beats accepted than programmed
  a_r5_no_overrun: assert property (@(posedge clk) disable iff (rst)
    busy |-> (accepted <= qwc));

endmodule

// File: rtl/dma1_trace.sv
module dma1_trace
  import dma1_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CHAN_ID = 2,
  parameter int PATH_ID = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_cfg,
  input  logic             ev_start,
  input  logic             ev_beat,
  input  logic             ev_done,
  input  logic [1:0]       mode,
  input  logic             dir,
  input  logic [31:0]      madr,
  input  logic [CNT_W-1:0] qwc,
  input  logic [CNT_W-1:0] accepted,
  input  logic [31:0]      beat_word,
  input  logic [1:0]       done_code,
  output logic             tr_valid,
  output logic [2:0]       tr_kind,
  output logic [31:0]      tr_arg0,
  output logic [31:0]      tr_arg1,
  output logic [31:0]      tr_arg2,
  output logic [31:0]      tr_arg3
);

  localparam logic [31:0] CHAN = 32'(CHAN_ID);
  localparam logic [31:0] PATH = 32'(PATH_ID);

  logic [CNT_W-1:0] to_go;
  assign to_go = qwc - accepted - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_valid <= 1'b0;
      tr_kind  <= '0;
      tr_arg0  <= '0;
      tr_arg1  <= '0;
      tr_arg2  <= '0;
      tr_arg3  <= '0;
    end else begin
      tr_valid <= ev_cfg || ev_start || ev_beat || ev_done;
      tr_arg0  <= CHAN;
      if (ev_cfg) begin
        tr_kind <= TK_CFG;
        tr_arg1 <= 32'({dir, mode});
        tr_arg2 <= madr;
        tr_arg3 <= 32'(qwc);
      end else if (ev_start) begin
        tr_kind <= TK_START;
        tr_arg1 <= 32'(qwc);
        tr_arg2 <= 32'(qwc);
        tr_arg3 <= PATH;
      end else if (ev_beat) begin
        tr_kind <= TK_BEAT;
        tr_arg1 <= 32'(accepted);
        tr_arg2 <= beat_word;
        tr_arg3 <= 32'(to_go);
      end else if (ev_done) begin
        tr_kind <= TK_DONE;
        tr_arg1 <= 32'(accepted);
        tr_arg2 <= 32'(done_code);
        tr_arg3 <= PATH;
      end
    end
  end

  // R6: at most one lifecycle event per cycle, so none is lost
  a_r6_one_event: assert property (@(posedge clk) disable iff (rst)
    $countones({ev_cfg, ev_start, ev_beat, ev_done}) <= 1);

endmodule

// File: rtl/dma1_xfer_ctrl.sv
module dma1_xfer_ctrl
  import dma1_pkg::*;
#(
  parameter int CHAN_ID = 2,
  parameter int PATH_ID = 1,
  parameter int QW_BITS = 128,
  parameter int BUF_AW  = 3,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               ld_we,
  input  logic [BUF_AW-1:0]  ld_addr,
  input  logic [QW_BITS-1:0] ld_data,
  output logic               pl_valid,
  output logic [QW_BITS-1:0] pl_data,
  input  logic               pl_ready,
  input  logic               cons_done,
  output logic               tr_valid,
  output logic [2:0]         tr_kind,
  output logic [31:0]        tr_arg0,
  output logic [31:0]        tr_arg1,
  output logic [31:0]        tr_arg2,
  output logic [31:0]        tr_arg3
);

  xfer_state_e      state;
  logic             busy, start_req, dir, rd_en;
  logic [1:0]       mode, done_code;
  logic [31:0]      madr;
  logic [CNT_W-1:0] qwc, accepted;
  logic [BUF_AW-1:0] rd_addr;
  logic             ev_cfg, ev_start, ev_beat, ev_done;

  dma1_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .state(state), .reg_rdata(reg_rdata),
    .start_req(start_req), .mode(mode), .dir(dir), .madr(madr), .qwc(qwc)
  );

  dma1_buf #(.AW(BUF_AW), .W(QW_BITS)) u_buf (
    .clk(clk), .wr_en(ld_we && !busy), .wr_addr(ld_addr), .wr_data(ld_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(pl_data)
  );

  dma1_fsm #(.CNT_W(CNT_W), .AW(BUF_AW)) u_fsm (
    .clk(clk), .rst(rst), .start_req(start_req), .mode(mode), .qwc(qwc),
    .pl_ready(pl_ready), .cons_done(cons_done), .state(state), .busy(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .pl_valid(pl_valid),
    .ev_cfg(ev_cfg), .ev_start(ev_start), .ev_beat(ev_beat), .ev_done(ev_done),
    .accepted(accepted), .done_code(done_code)
  );

  dma1_trace #(.CNT_W(CNT_W), .CHAN_ID(CHAN_ID), .PATH_ID(PATH_ID)) u_trace (
    .clk(clk), .rst(rst), .ev_cfg(ev_cfg), .ev_start(ev_start),
    .ev_beat(ev_beat), .ev_done(ev_done), .mode(mode), .dir(dir),
    .madr(madr), .qwc(qwc), .accepted(accepted), .beat_word(pl_data[31:0]),
    .done_code(done_code), .tr_valid(tr_valid), .tr_kind(tr_kind),
    .tr_arg0(tr_arg0), .tr_arg1(tr_arg1), .tr_arg2(tr_arg2), .tr_arg3(tr_arg3)
  );

  // R5: a stalled beat keeps its contents until taken
  a_r5_hold_payload: assert property (@(posedge clk) disable iff (rst)
    (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data)));

endmodule

// File: tb/tb_dma1_xfer_ctrl.sv
module tb_dma1_xfer_ctrl;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int QW = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, reg_we, ld_we, pl_valid, pl_ready, cons_done, tr_valid;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, tr_arg0, tr_arg1, tr_arg2, tr_arg3;
  logic [AW-1:0] ld_addr;
  logic [QW-1:0] ld_data, pl_data;
  logic [2:0] tr_kind;

  dma1_xfer_ctrl dut (.*);

  int n_chk = 0, n_fail = 0, ready_pct = 100, n_done_seen = 0;
  logic [QW-1:0] mem_m [DEPTH];
  int unsigned tk_q[$];
  logic [31:0] a0_q[$], a1_q[$], a2_q[$], a3_q[$];
  logic [QW-1:0] bt_q[$];

  task automatic chk(input string req, input string what,
                     input logic [QW-1:0] act, input logic [QW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [QW-1:0] rnd_qw();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic int exp_code(input int qwc, input int mode);
    if (mode != 0) return 3;
    if (qwc == 0) return 2;
    return 1;
  endfunction

  // consumer: drive ready, then record the beat taken at the next edge
  initial begin
    pl_ready = 1'b0;
    forever begin
      @(negedge clk);
      pl_ready = (($urandom % 100) < ready_pct);
      #1;
      if (pl_valid && pl_ready) bt_q.push_back(pl_data);
    end
  end

  // trace recorder
  initial begin
    forever begin
      @(negedge clk);
      if (tr_valid) begin
        tk_q.push_back(32'(tr_kind));
        a0_q.push_back(tr_arg0); a1_q.push_back(tr_arg1);
        a2_q.push_back(tr_arg2); a3_q.push_back(tr_arg3);
        if (tr_kind == 3'd4) n_done_seen++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic buf_ld(input int i, input logic [QW-1:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(i); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run_xfer(input int qwc, input int mode, input bit dir,
                          input logic [31:0] madr, input bit early, input bit poke);
    logic [31:0] d;
    int code, base, nexp;
    tk_q.delete(); a0_q.delete(); a1_q.delete(); a2_q.delete(); a3_q.delete();
    bt_q.delete();
    n_done_seen = 0;
    code = exp_code(qwc, mode);
    reg_wr(2'd1, madr);
    reg_wr(2'd2, 32'(qwc));
    if (early) cons_done = 1'b1;
    reg_wr(2'd0, (32'(dir) << 3) | (32'(mode) << 1) | 32'd1);
    if (poke) begin
      reg_wr(2'd1, ~madr);                 // R11: ignored while busy
      reg_wr(2'd0, 32'h5);                 // R11: second start ignored
      buf_ld(qwc - 1, rnd_qw());           // R12: ignored while busy
    end
    if (code == 1) begin
      while (bt_q.size() < qwc) @(negedge clk);
      if (!early) begin
        repeat (3) @(negedge clk);
        reg_rd(2'd0, d);
        chk("R7", "state after last beat, no strobe", 128'(d[5:4]), 128'd2);
        chk("R7", "done traces before strobe", 128'(n_done_seen), 128'd0);
        @(negedge clk);
        cons_done = 1'b1;
      end
    end
    while (n_done_seen == 0) @(negedge clk);
    cons_done = 1'b0;
    repeat (2) @(negedge clk);
    reg_rd(2'd0, d);
    chk("R8", "busy after done", 128'(d[0]), 128'd0);
    chk("R8", "state after done", 128'(d[5:4]), 128'd0);
    chk("R11", "mode/dir kept", 128'(d[3:1]), 128'({dir, 2'(mode)}));
    reg_rd(2'd1, d);
    chk("R11", "address kept", 128'(d), 128'(madr));
    chk("R5", "beat count", 128'(bt_q.size()), 128'((code == 1) ? qwc : 0));
    if (code == 1)
      for (int i = 0; i < bt_q.size() && i < qwc; i++)
        chk("R5", $sformatf("beat %0d data", i), bt_q[i], mem_m[i % DEPTH]);
    nexp = (code == 1) ? qwc + 3 : 2;
    chk((code == 2) ? "R9" : (code == 3) ? "R10" : "R4", "trace count",
        128'(tk_q.size()), 128'(nexp));
    if (tk_q.size() == nexp) begin
      chk("R3", "cfg kind", 128'(tk_q[0]), 128'd1);
      chk("R3", "cfg chan", 128'(a0_q[0]), 128'd2);
      chk("R3", "cfg ctrl", 128'(a1_q[0]), 128'({dir, 2'(mode)}));
      chk("R3", "cfg addr", 128'(a2_q[0]), 128'(madr));
      chk("R3", "cfg count", 128'(a3_q[0]), 128'(qwc));
      base = 1;
      if (code == 1) begin
        chk("R4", "start kind", 128'(tk_q[1]), 128'd2);
        chk("R4", "start count", 128'(a1_q[1]), 128'(qwc));
        chk("R4", "start planned", 128'(a2_q[1]), 128'(qwc));
        chk("R4", "start path", 128'(a3_q[1]), 128'd1);
        for (int i = 0; i < qwc; i++) begin
          chk("R6", "beat kind", 128'(tk_q[2+i]), 128'd3);
          chk("R6", "beat index", 128'(a1_q[2+i]), 128'(i));
          chk("R6", "beat word", 128'(a2_q[2+i]), 128'(mem_m[i % DEPTH][31:0]));
          chk("R6", "beat to-go", 128'(a3_q[2+i]), 128'(qwc - 1 - i));
        end
        base = qwc + 2;
      end
      chk("R8", "done kind", 128'(tk_q[base]), 128'd4);
      chk("R8", "done chan", 128'(a0_q[base]), 128'd2);
      chk("R8", "done beats", 128'(a1_q[base]), 128'((code == 1) ? qwc : 0));
      chk((code == 2) ? "R9" : (code == 3) ? "R10" : "R8", "done code",
          128'(a2_q[base]), 128'(code));
      chk("R8", "done path", 128'(a3_q[base]), 128'd1);
    end
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    ld_we = 1'b0; ld_addr = '0; ld_data = '0; cons_done = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1", "pl_valid", 128'(pl_valid), 128'd0);
    chk("R1", "tr_valid", 128'(tr_valid), 128'd0);
    reg_rd(2'd0, d);
    chk("R1", "ctrl read", 128'(d), 128'd0);
    // R2
    reg_wr(2'd1, 32'hA5C3_0F10);
    reg_rd(2'd1, d);
    chk("R2", "address readback", 128'(d), 128'hA5C3_0F10);
    reg_wr(2'd2, 32'h0001_0007);
    reg_rd(2'd2, d);
    chk("R2", "count readback", 128'(d), 128'h7);
    reg_wr(2'd0, 32'hC);
    reg_rd(2'd0, d);
    chk("R2", "ctrl without start", 128'(d), 128'hC);
    reg_wr(2'd0, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      mem_m[i] = rnd_qw();
      buf_ld(i, mem_m[i]);
    end
    // directed corners
    ready_pct = 100; run_xfer(1, 0, 1'b0, 32'h1000_0000, 1'b0, 1'b0);
    run_xfer(0, 0, 1'b1, 32'h2000_0040, 1'b0, 1'b0);   // R9
    run_xfer(4, 2, 1'b0, 32'h3000_0080, 1'b0, 1'b0);   // R10
    ready_pct = 30; run_xfer(6, 0, 1'b1, 32'h4000_00C0, 1'b0, 1'b1); // R11 R12
    ready_pct = 60; run_xfer(3, 0, 1'b0, 32'h5000_0100, 1'b1, 1'b0); // R7 early strobe
    ready_pct = 80; run_xfer(12, 0, 1'b1, 32'h6000_0140, 1'b0, 1'b0); // R5 wrap
    // random mix
    for (int k = 0; k < 10; k++) begin
      int j;
      j = $urandom % DEPTH;
      mem_m[j] = rnd_qw();
      buf_ld(j, mem_m[j]);
      ready_pct = 30 + ($urandom % 71);
      run_xfer(1 + ($urandom % 12), 0, 1'($urandom), $urandom,
               1'($urandom % 3 == 0), 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule